// File: doc/BRIEF.md
# Overlapping Strip Stereo Sequencer

This block lets a disparity correlator whose line buffers hold only a narrow window work across a frame that is far wider than those buffers. The frame is cut into vertical strips 2·D columns wide, where D is the disparity search range. Neighbouring strips overlap by D columns. For each strip the sequencer walks the rows from top to bottom. In each row it fetches left and right pixels from frame memory, left to right, and streams them to the correlator as pairs.

The correlator returns one disparity value for every pair it receives. In each row of a strip, the first D results lack enough search history, so the block throws them away. It writes the remaining D results into a single output frame. Strip k fills output columns k·D to k·D+D−1, so the strips together tile the output with no gap and no overlap. The input window of strip k begins at column k·D−D. Columns to the left of the image are fed as zero pixels and are never read from memory.

The line storage the correlator needs therefore depends only on D, not on the frame width. The cost is that the frame takes W/D passes. Width, height, search range and the pixel and disparity widths are parameters. The width must be a whole multiple of D, and this is enforced when the design is elaborated.

Top module: `strip_stereo_seq`

## Requirements
- R1: After reset, and whenever no frame is in progress, `memRdEn`, `corrInValid`, `outWrEn` and `done` stay low.
- R2: Pairs reach the correlator in this order: strip k = 0 … W/D−1, then row 0 … H−1 within the strip, then window position c = 0 … 2D−1 within the row. The image column is k·D−D+c.
- R3: A window position whose image column is below zero is delivered as a zero left pixel and a zero right pixel, with no memory read. Each memory read uses the row-major address row·W+column, which is always below W·H. A frame therefore issues exactly (W/D)·H·2D − H·D reads.
- R4: A delivered pair holds the left and right pixels returned by the read at one address. Memory returns data one cycle after `memRdEn`.
- R5: In each row of each strip, the first D correlator results are accepted and discarded. None of them produces a write, so a frame issues exactly W·H writes.
- R6: The result at window position c ≥ D of row r in strip k is written unchanged to address r·W + k·D + (c−D). Every output address is written exactly once per frame.
- R7: Backpressure on `corrInReady` or `outWrReady` stalls the block without losing or repeating pixels. An offered pair or write holds its value until it is accepted, and a frame delivers exactly (W/D)·H·2D pairs.
- R8: `done` is high for exactly one cycle. That cycle immediately follows the cycle in which the last output write was accepted.
- R9: A `start` pulse while a frame is in progress is ignored. The frame continues undisturbed and produces a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a frame when the block is idle |
| done | output | 1 | One-cycle pulse after the last output write |
| memRdEn | output | 1 | Frame memory read strobe |
| memRdAddr | output | ADDR_W = clog2(IMG_W·IMG_H) | Row-major pixel address |
| memRdLeft | input | PIX_W | Left image pixel, valid one cycle after the read |
| memRdRight | input | PIX_W | Right image pixel, valid one cycle after the read |
| corrInValid | output | 1 | Pixel pair offered to the correlator |
| corrInReady | input | 1 | Correlator accepts the pair |
| corrInLeft | output | PIX_W | Left pixel of the pair |
| corrInRight | output | PIX_W | Right pixel of the pair |
| corrOutValid | input | 1 | Correlator offers a disparity result |
| corrOutReady | output | 1 | Block accepts the result |
| corrOutDisp | input | DISP_W | Disparity result |
| outWrEn | output | 1 | Output frame write request |
| outWrReady | input | 1 | Output port accepts the write |
| outWrAddr | output | ADDR_W | Row-major output address |
| outWrData | output | DISP_W | Disparity written |

## Verification
The bench runs a 16×4 frame with D=4 and tracks every pair and every write against arithmetic expectations. It checks three risky areas.

- **Left padding on strip 0.** A fetch window that is off by one would read a negative column or duplicate a pixel. That shows up as a wrong pair or as a wrong read count.
- **The discard boundary.** Keeping the first half of a row instead of the second would put values at the wrong addresses. It would also write some addresses twice and leave others empty.
- **Random stalls on both streams.** An occupancy error in the two-entry pixel buffer under random stalls would drop or repeat a pair and shift every later result.

The bench also places `done` to the exact cycle and sends a `start` in the middle of a frame. A design that restarted on that pulse would replay strip 0 and break the pair sequence.

// File: rtl/stripseq_pkg.sv
package stripseq_pkg;

  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic fetchGo;    // launch one window slot this cycle
    logic fetchPad;   // the slot lies left of the image: zero pair, no read
    logic outEnable;  // a frame is in progress, result stream is live
    logic keepBeat;   // the current result position is in the kept half
  } seqStrobe_t;

  // Status returned by the datapath.
  typedef struct packed {
    logic fetchRoom;  // the pixel buffer can absorb one more slot
    logic outBeat;    // a correlator result was accepted this cycle
  } seqStatus_t;

endpackage

// File: rtl/stripseq_ctrl.sv
module stripseq_ctrl
  import stripseq_pkg::*;
#(
  parameter int IMG_W      = 640,
  parameter int IMG_H      = 480,
  parameter int DISP_RANGE = 64,
  localparam int NSTRIP    = IMG_W / DISP_RANGE,
  localparam int SPAN      = 2 * DISP_RANGE,
  localparam int SW        = (NSTRIP > 1) ? $clog2(NSTRIP) : 1,
  localparam int RW        = (IMG_H > 1) ? $clog2(IMG_H) : 1,
  localparam int CW        = $clog2(SPAN),
  localparam int XW        = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  seqStatus_t    status,
  output seqStrobe_t    strobe,
  output logic [RW-1:0] fetchRow,
  output logic [XW-1:0] fetchCol,
  output logic [RW-1:0] outRow,
  output logic [SW-1:0] outStrip,
  output logic [CW-1:0] outCol,
  output logic          done
);

  logic          busy;
  logic          fetchActive;
  logic [SW-1:0] fStrip;
  logic [RW-1:0] fRow;
  logic [CW-1:0] fCol;
  logic [SW-1:0] oStrip;
  logic [RW-1:0] oRow;
  logic [CW-1:0] oCol;

  logic fColEnd, fRowEnd, fetchLast;
  logic oColEnd, oRowEnd, outLast;

  always_comb begin
    fColEnd   = (fCol == CW'(SPAN - 1));
    fRowEnd   = (fRow == RW'(IMG_H - 1));
    fetchLast = fColEnd && fRowEnd && (fStrip == SW'(NSTRIP - 1));
    oColEnd   = (oCol == CW'(SPAN - 1));
    oRowEnd   = (oRow == RW'(IMG_H - 1));
    outLast   = oColEnd && oRowEnd && (oStrip == SW'(NSTRIP - 1));
  end

  always_comb begin
    strobe.fetchGo   = fetchActive && status.fetchRoom;
    strobe.fetchPad  = (fStrip == '0) && (fCol < CW'(DISP_RANGE));
    strobe.outEnable = busy;
    strobe.keepBeat  = (oCol >= CW'(DISP_RANGE));
  end

  // Window column k*D - D + c; meaningless (and unused) while padding.
  assign fetchCol = XW'(int'(fStrip) * DISP_RANGE + int'(fCol) - DISP_RANGE);
  assign fetchRow = fRow;
  assign outRow   = oRow;
  assign outStrip = oStrip;
  assign outCol   = oCol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy        <= 1'b0;
      fetchActive <= 1'b0;
      fStrip      <= '0;
      fRow        <= '0;
      fCol        <= '0;
      oStrip      <= '0;
      oRow        <= '0;
      oCol        <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy        <= 1'b1;
          fetchActive <= 1'b1;
          fStrip      <= '0;
          fRow        <= '0;
          fCol        <= '0;
          oStrip      <= '0;
          oRow        <= '0;
          oCol        <= '0;
        end
      end else begin
        // Fetch walk: column, then row, then strip.
        if (strobe.fetchGo) begin
          if (fColEnd) begin
            fCol <= '0;
            if (fRowEnd) begin
              fRow   <= '0;
              fStrip <= fStrip + 1'b1;
            end else begin
              fRow <= fRow + 1'b1;
            end
          end else begin
            fCol <= fCol + 1'b1;
          end
          if (fetchLast) fetchActive <= 1'b0;
        end
        // Result walk follows the same order, one step per accepted result.
        if (status.outBeat) begin
          if (oColEnd) begin
            oCol <= '0;
            if (oRowEnd) begin
              oRow   <= '0;
              oStrip <= oStrip + 1'b1;
            end else begin
              oRow <= oRow + 1'b1;
            end
          end else begin
            oCol <= oCol + 1'b1;
          end
          if (outLast) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/stripseq_dp.sv
module stripseq_dp
  import stripseq_pkg::*;
#(
  parameter int IMG_W      = 640,
  parameter int IMG_H      = 480,
  parameter int DISP_RANGE = 64,
  parameter int PIX_W      = 8,
  parameter int DISP_W     = 8,
  localparam int NSTRIP    = IMG_W / DISP_RANGE,
  localparam int SPAN      = 2 * DISP_RANGE,
  localparam int SW        = (NSTRIP > 1) ? $clog2(NSTRIP) : 1,
  localparam int RW        = (IMG_H > 1) ? $clog2(IMG_H) : 1,
  localparam int CW        = $clog2(SPAN),
  localparam int XW        = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int AW        = $clog2(IMG_W * IMG_H)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  output seqStatus_t        status,
  input  logic [RW-1:0]     fetchRow,
  input  logic [XW-1:0]     fetchCol,
  input  logic [RW-1:0]     outRow,
  input  logic [SW-1:0]     outStrip,
  input  logic [CW-1:0]     outCol,
  output logic              memRdEn,
  output logic [AW-1:0]     memRdAddr,
  input  logic [PIX_W-1:0]  memRdLeft,
  input  logic [PIX_W-1:0]  memRdRight,
  output logic              corrInValid,
  input  logic              corrInReady,
  output logic [PIX_W-1:0]  corrInLeft,
  output logic [PIX_W-1:0]  corrInRight,
  input  logic              corrOutValid,
  output logic              corrOutReady,
  input  logic [DISP_W-1:0] corrOutDisp,
  output logic              outWrEn,
  input  logic              outWrReady,
  output logic [AW-1:0]     outWrAddr,
  output logic [DISP_W-1:0] outWrData
);

  localparam int DEPTH = 2;

  // One slot in flight through the synchronous read.
  logic pendValid, pendPad;

  logic [PIX_W-1:0] bufLeft  [DEPTH];
  logic [PIX_W-1:0] bufRight [DEPTH];
  logic             wrPtr, rdPtr;
  logic [1:0]       bufCount;
  logic             push, pop;
  logic [2:0]       occAfter;

  assign memRdEn   = strobe.fetchGo && !strobe.fetchPad;
  assign memRdAddr = AW'(int'(fetchRow) * IMG_W + int'(fetchCol));

  assign push = pendValid;
  assign pop  = corrInValid && corrInReady;

  // Entries held plus the one landing, minus the one leaving.
  assign occAfter         = 3'(bufCount) + 3'(pendValid) - 3'(pop);
  assign status.fetchRoom = (occAfter <= 3'd1);

  assign corrInValid = (bufCount != 2'd0);
  assign corrInLeft  = bufLeft[rdPtr];
  assign corrInRight = bufRight[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendPad   <= 1'b0;
      wrPtr     <= 1'b0;
      rdPtr     <= 1'b0;
      bufCount  <= 2'd0;
    end else begin
      pendValid <= strobe.fetchGo;
      pendPad   <= strobe.fetchPad;
      if (push) wrPtr <= ~wrPtr;
      if (pop)  rdPtr <= ~rdPtr;
      bufCount <= bufCount + 2'(push) - 2'(pop);
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : gSlot
    always_ff @(posedge clk) begin
      if (push && (wrPtr == 1'(e))) begin
        bufLeft[e]  <= pendPad ? '0 : memRdLeft;
        bufRight[e] <= pendPad ? '0 : memRdRight;
      end
    end
  end

  // Result side: discard the first half of each row, write the second half.
  assign corrOutReady  = strobe.outEnable && (!strobe.keepBeat || outWrReady);
  assign outWrEn       = strobe.outEnable && strobe.keepBeat && corrOutValid;
  assign outWrData     = corrOutDisp;
  assign outWrAddr     = AW'(int'(outRow) * IMG_W + int'(outStrip) * DISP_RANGE
                             + int'(outCol) - DISP_RANGE);
  assign status.outBeat = corrOutValid && corrOutReady;

endmodule

// File: rtl/strip_stereo_seq.sv
module strip_stereo_seq
  import stripseq_pkg::*;
#(
  parameter int IMG_W      = 640,
  parameter int IMG_H      = 480,
  parameter int DISP_RANGE = 64,
  parameter int PIX_W      = 8,
  parameter int DISP_W     = 8,
  localparam int NSTRIP    = IMG_W / DISP_RANGE,
  localparam int SPAN      = 2 * DISP_RANGE,
  localparam int SW        = (NSTRIP > 1) ? $clog2(NSTRIP) : 1,
  localparam int RW        = (IMG_H > 1) ? $clog2(IMG_H) : 1,
  localparam int CW        = $clog2(SPAN),
  localparam int XW        = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int AW        = $clog2(IMG_W * IMG_H)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              done,
  output logic              memRdEn,
  output logic [AW-1:0]     memRdAddr,
  input  logic [PIX_W-1:0]  memRdLeft,
  input  logic [PIX_W-1:0]  memRdRight,
  output logic              corrInValid,
  input  logic              corrInReady,
  output logic [PIX_W-1:0]  corrInLeft,
  output logic [PIX_W-1:0]  corrInRight,
  input  logic              corrOutValid,
  output logic              corrOutReady,
  input  logic [DISP_W-1:0] corrOutDisp,
  output logic              outWrEn,
  input  logic              outWrReady,
  output logic [AW-1:0]     outWrAddr,
  output logic [DISP_W-1:0] outWrData
);

  // Strips tile the width exactly; any remainder is a configuration error.
  if ((IMG_W % DISP_RANGE) != 0) begin : gWidthCheck
    $error("IMG_W must be a whole multiple of DISP_RANGE");
  end

  seqStrobe_t    strobe;
  seqStatus_t    status;
  logic [RW-1:0] fetchRow;
  logic [XW-1:0] fetchCol;
  logic [RW-1:0] outRow;
  logic [SW-1:0] outStrip;
  logic [CW-1:0] outCol;

  stripseq_ctrl #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .DISP_RANGE(DISP_RANGE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .status(status), .strobe(strobe),
    .fetchRow(fetchRow), .fetchCol(fetchCol),
    .outRow(outRow), .outStrip(outStrip), .outCol(outCol),
    .done(done)
  );

  stripseq_dp #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .DISP_RANGE(DISP_RANGE),
    .PIX_W(PIX_W), .DISP_W(DISP_W)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .status(status),
    .fetchRow(fetchRow), .fetchCol(fetchCol),
    .outRow(outRow), .outStrip(outStrip), .outCol(outCol),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdLeft(memRdLeft), .memRdRight(memRdRight),
    .corrInValid(corrInValid), .corrInReady(corrInReady),
    .corrInLeft(corrInLeft), .corrInRight(corrInRight),
    .corrOutValid(corrOutValid), .corrOutReady(corrOutReady),
    .corrOutDisp(corrOutDisp),
    .outWrEn(outWrEn), .outWrReady(outWrReady),
    .outWrAddr(outWrAddr), .outWrData(outWrData)
  );

endmodule

// File: rtl/stripseq_chk.sv
module stripseq_chk #(
  parameter int IMG_W      = 640,
  parameter int IMG_H      = 480,
  parameter int PIX_W      = 8,
  parameter int DISP_W     = 8,
  localparam int AW        = $clog2(IMG_W * IMG_H)
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              memRdEn,
  input logic [AW-1:0]     memRdAddr,
  input logic              corrInValid,
  input logic              corrInReady,
  input logic [PIX_W-1:0]  corrInLeft,
  input logic [PIX_W-1:0]  corrInRight,
  input logic              outWrEn,
  input logic              outWrReady,
  input logic [AW-1:0]     outWrAddr,
  input logic [DISP_W-1:0] outWrData
);

  AST_READ_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (int'(memRdAddr) < IMG_W * IMG_H)); // R3

  AST_PAIR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (corrInValid && !corrInReady) |=>
      (corrInValid && $stable(corrInLeft) && $stable(corrInRight))); // R7

  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (outWrEn && !outWrReady) |=>
      (outWrEn && $stable(outWrAddr) && $stable(outWrData))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(outWrEn && outWrReady)); // R8

endmodule

bind strip_stereo_seq stripseq_chk #(
  .IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W), .DISP_W(DISP_W)
) uChk (
  .clk(clk), .rstN(rstN), .done(done),
  .memRdEn(memRdEn), .memRdAddr(memRdAddr),
  .corrInValid(corrInValid), .corrInReady(corrInReady),
  .corrInLeft(corrInLeft), .corrInRight(corrInRight),
  .outWrEn(outWrEn), .outWrReady(outWrReady),
  .outWrAddr(outWrAddr), .outWrData(outWrData)
);

// File: tb/strip_stereo_seq_test.sv
`timescale 1ns/1ps
module strip_stereo_seq_test;

  localparam int W   = 16;
  localparam int H   = 4;
  localparam int D   = 4;
  localparam int PW  = 8;
  localparam int DW  = 8;
  localparam int AW  = $clog2(W * H);
  localparam int NS  = W / D;
  localparam int PAIRS = NS * H * 2 * D;
  localparam int READS = PAIRS - H * D;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          done;
  logic          memRdEn;
  logic [AW-1:0] memRdAddr;
  logic [PW-1:0] memRdLeft = '0, memRdRight = '0;
  logic          corrInValid;
  logic          corrInReady = 1'b0;
  logic [PW-1:0] corrInLeft, corrInRight;
  logic          corrOutValid;
  logic          corrOutReady;
  logic [DW-1:0] corrOutDisp;
  logic          outWrEn;
  logic          outWrReady = 1'b0;
  logic [AW-1:0] outWrAddr;
  logic [DW-1:0] outWrData;

  strip_stereo_seq #(
    .IMG_W(W), .IMG_H(H), .DISP_RANGE(D), .PIX_W(PW), .DISP_W(DW)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .done(done),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdLeft(memRdLeft), .memRdRight(memRdRight),
    .corrInValid(corrInValid), .corrInReady(corrInReady),
    .corrInLeft(corrInLeft), .corrInRight(corrInRight),
    .corrOutValid(corrOutValid), .corrOutReady(corrOutReady),
    .corrOutDisp(corrOutDisp),
    .outWrEn(outWrEn), .outWrReady(outWrReady),
    .outWrAddr(outWrAddr), .outWrData(outWrData)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] leftPix(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] rightPix(input int a);
    return 8'((a * 13 + 5) & 255);
  endfunction
  function automatic logic [7:0] corrFn(input logic [7:0] l, input logic [7:0] r);
    return l + 8'(3 * int'(r));
  endfunction

  // Frame memory: synchronous read, one cycle latency.
  always @(posedge clk) begin
    if (memRdEn) begin
      memRdLeft  <= leftPix(int'(memRdAddr));
      memRdRight <= rightPix(int'(memRdAddr));
    end
  end

  // Correlator model: one result per pair, queued, with random gaps.
  int           mode = 0;
  logic [15:0]  lfsr = 16'hACE1;
  logic [DW-1:0] q [64];
  logic [5:0]   qHead = '0, qTail = '0;
  logic         showReg = 1'b0;
  logic [5:0]   qFill;

  assign qFill        = qTail - qHead;
  assign corrOutValid = (qHead != qTail) && showReg;
  assign corrOutDisp  = q[qHead];

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (corrInValid && corrInReady) begin
      q[qTail] <= corrFn(corrInLeft, corrInRight);
      qTail    <= qTail + 1'b1;
    end
    if (corrOutValid && corrOutReady) qHead <= qHead + 1'b1;
    if (!corrOutValid || corrOutReady) showReg <= (mode == 0) ? 1'b1 : lfsr[2];
    corrInReady <= ((mode == 0) ? 1'b1 : (lfsr[5] | lfsr[7])) && (qFill < 6'd40);
    outWrReady  <= (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[9] : (lfsr[9] & lfsr[11]);
  end

  // Monitors, sampled on the falling edge.
  int expK = 0, expR = 0, expC = 0;
  int framePairs = 0, frameReads = 0, frameWrites = 0, doneCount = 0;
  bit expectDone = 1'b0;
  bit frameDone  = 1'b0;
  int writeCnt [W * H];

  always @(negedge clk) begin
    if (rstN) begin
      // done placement
      if (expectDone) begin
        chk(done == 1'b1, "R8 done one cycle after last write", int'(done), 1);
        expectDone = 1'b0;
      end else if (done) begin
        chk(1'b0, "R8 done outside its cycle", 1, 0);
      end
      if (done) begin
        doneCount++;
        frameDone = 1'b1;
      end

      // Read addresses
      if (memRdEn) begin
        frameReads++;
        chk(int'(memRdAddr) < W * H, "R3 read address in frame", int'(memRdAddr), W * H - 1);
      end

      // Pair order and content
      if (corrInValid && corrInReady) begin
        int col;
        bit pad;
        logic [7:0] eL, eR;
        col = expK * D - D + expC;
        pad = (col < 0);
        eL  = pad ? 8'd0 : leftPix(expR * W + col);
        eR  = pad ? 8'd0 : rightPix(expR * W + col);
        if (pad) begin
          chk(corrInLeft == eL, "R3 padded left pixel", int'(corrInLeft), int'(eL));
          chk(corrInRight == eR, "R3 padded right pixel", int'(corrInRight), int'(eR));
        end else begin
          chk(corrInLeft == eL, "R2 left pixel order", int'(corrInLeft), int'(eL));
          chk(corrInRight == eR, "R4 right pixel paired", int'(corrInRight), int'(eR));
        end
        framePairs++;
        if (expC == 2 * D - 1) begin
          expC = 0;
          if (expR == H - 1) begin expR = 0; expK++; end
          else expR++;
        end else expC++;
      end

      // Writes
      if (outWrEn && outWrReady) begin
        int a;
        logic [7:0] eD;
        a  = int'(outWrAddr);
        eD = corrFn(leftPix(a), rightPix(a));
        chk(outWrData == eD, "R6 written disparity", int'(outWrData), int'(eD));
        chk(writeCnt[a] == 0, "R6 address written once", writeCnt[a], 0);
        writeCnt[a]++;
        frameWrites++;
        if (frameWrites == W * H) expectDone = 1'b1;
      end
    end
  end

  task automatic runFrame(input int m, input bit midStart);
    int cyc;
    mode = m;
    foreach (writeCnt[i]) writeCnt[i] = 0;
    expK = 0; expR = 0; expC = 0;
    framePairs = 0; frameReads = 0; frameWrites = 0; doneCount = 0;
    frameDone = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!frameDone && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (midStart && cyc == 40) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    chk(frameDone, "watchdog frame completion", cyc, 0);
    repeat (6) begin
      @(negedge clk);
      chk(!memRdEn && !corrInValid && !outWrEn, "R1 quiet after frame",
          int'({memRdEn, corrInValid, outWrEn}), 0);
    end
    chk(framePairs == PAIRS, "R7 pairs per frame", framePairs, PAIRS);
    chk(frameReads == READS, "R3 reads per frame", frameReads, READS);
    chk(frameWrites == W * H, "R5 writes per frame", frameWrites, W * H);
    chk(doneCount == 1, "R8 single done", doneCount, 1);
    if (midStart) chk(doneCount == 1 && framePairs == PAIRS,
                      "R9 start during frame ignored", framePairs, PAIRS);
    for (int a = 0; a < W * H; a++)
      if (writeCnt[a] != 1) chk(1'b0, "R6 address coverage", writeCnt[a], 1);
    chk(1'b1, "R6 coverage scan", 0, 0);
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      chk(!done && !memRdEn && !corrInValid && !outWrEn, "R1 outputs in reset",
          int'({done, memRdEn, corrInValid, outWrEn}), 0);
    end
    rstN = 1'b1;
    repeat (8) begin
      @(negedge clk);
      chk(!done && !memRdEn && !corrInValid && !outWrEn, "R1 idle before start",
          int'({done, memRdEn, corrInValid, outWrEn}), 0);
    end
    runFrame(0, 1'b0);
    runFrame(1, 1'b1);
    runFrame(2, 1'b0);
    runFrame(1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule